// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Scoreboard

This block decides, every cycle, how many of two decoded instructions may leave decode for a pipeline with three execution units: a single-cycle adder, a single-cycle shifter and a pipelined multiplier with a two-cycle result latency. Instructions issue strictly in program order. Slot 0 always holds the older instruction. Results may still return out of order. Each instruction names one destination register and two source registers. Register 0 stands for "no operand" or "no result". Each instruction also carries a two-bit unit class. The block answers with an issue count of 0, 1 or 2, and the front end consumes that many instructions from the head of its queue.

Per architectural register, a scoreboard holds a busy flag and a countdown of the cycles left until the newest pending write lands. Issue sets the entry. A write-back presented on either of the two write-back ports clears it, but only once the countdown has run out. A write-back that belongs to an older, overtaken write therefore leaves the register busy. The block checks each slot against the in-flight writes for read-after-write and write-after-write hazards. It checks the younger slot against the older one for operand dependences and for use of the same unit.

A two-state machine protects the two result ports. In state WB_CLEAR no multiply was issued in the previous cycle. In state WB_RESERVED a multiply issued last cycle will take one result port in the cycle where this cycle's single-cycle operations return. The machine takes the transition "multiply issued" into WB_RESERVED from either state, and the transition "no multiply issued" into WB_CLEAR from either state. In WB_RESERVED, a pair of two single-cycle operations issues only the older one.

Top module: `dis_issue_ctl`

## Requirements
- R1: `issue_cnt` reports how many instructions issue this cycle, in the range 0 to 2. Slot 0 is the older instruction, and a value of 1 always means slot 0 alone.
- R2: Slot 1 never issues unless slot 0 issues in the same cycle. This holds even when slot 1 is free of hazards, and even when slot 0 is not valid.
- R3: Unit codes are 0 = adder, 1 = shifter, 2 = multiplier, and code 3 is treated as the adder. When both slots need the same unit, only slot 0 may issue. A multiply may issue in consecutive cycles.
- R4: An instruction whose nonzero source register is busy does not issue. A write-back arriving in that same cycle does not release the register for that decision.
- R5: The result latency is 1 cycle for adder and shifter operations and 2 cycles for multiplies. An instruction does not issue when its nonzero destination is busy and the pending write's remaining cycles, counted as 0 when the write lands this cycle, are at least the new latency.
- R6: Slot 1 does not issue when either of its nonzero sources, or its nonzero destination, equals the destination of slot 0.
- R7: Register 0 is never busy and never causes a stall, whether it appears as a source or as a destination.
- R8: When a multiply issued in the previous cycle and both slots hold single-cycle operations, slot 1 does not issue.
- R9: An issued instruction with a nonzero destination marks it busy from the next cycle. A write-back clears the register only when its countdown is 0. When an issue and a write-back hit the same register in the same cycle, the issue wins.
- R10: Reset clears every busy flag and countdown and returns the port state machine to WB_CLEAR.
- R11: `reg_busy` shows the busy flag of every register, with bit i for register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_unit | input | 2 | Older slot unit class |
| s0_dst | input | AW | Older slot destination (0 = none) |
| s0_src_a | input | AW | Older slot first source (0 = none) |
| s0_src_b | input | AW | Older slot second source (0 = none) |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_unit | input | 2 | Younger slot unit class |
| s1_dst | input | AW | Younger slot destination |
| s1_src_a | input | AW | Younger slot first source |
| s1_src_b | input | AW | Younger slot second source |
| wb0_valid | input | 1 | Result port 0 writes back this cycle |
| wb0_reg | input | AW | Register written through result port 0 |
| wb1_valid | input | 1 | Result port 1 writes back this cycle |
| wb1_reg | input | AW | Register written through result port 1 |
| issue_cnt | output | 2 | Number of instructions issuing this cycle |
| reg_busy | output | NREG | Busy flag per register |

## Verification
A busy flag that stays set too long shows up as a stalled issue count on the first instruction that reads that register. A flag that clears too early shows up as an issue that should have been held. Both are visible in the same cycle as the offending read, and `reg_busy` exposes the flag one cycle after each issue or write-back. A wrong countdown shows only when a write-after-write or overtaken write-back case is presented, so the stimulus steps through back-to-back multiplies to the same register. A port state machine stuck in either state shows in the cycle right after a multiply, as a pair of single-cycle operations that issues wrongly or is wrongly held.

// File: rtl/dis_pkg.sv
`timescale 1ns/1ps
package dis_pkg;

    typedef enum logic [1:0] {
        FU_ADD = 2'd0,
        FU_SHF = 2'd1,
        FU_MUL = 2'd2,
        FU_RSV = 2'd3
    } fu_e;

    typedef enum logic {
        WB_CLEAR    = 1'b0,
        WB_RESERVED = 1'b1
    } port_st_e;

    localparam int MUL_LAT = 2;
    localparam int ALU_LAT = 1;
    localparam int CW      = $clog2(MUL_LAT + 1);

    function automatic fu_e fu_norm(input logic [1:0] code);
        fu_e r;
        unique case (code)
            2'd1:    r = FU_SHF;
            2'd2:    r = FU_MUL;
            default: r = FU_ADD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dis_scoreboard.sv
`timescale 1ns/1ps
module dis_scoreboard
    import dis_pkg::*;
#(
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set0_en,
    input  logic [AW-1:0]             set0_reg,
    input  logic [CW-1:0]             set0_cnt,
    input  logic                      set1_en,
    input  logic [AW-1:0]             set1_reg,
    input  logic [CW-1:0]             set1_cnt,
    input  logic                      wb0_en,
    input  logic [AW-1:0]             wb0_reg,
    input  logic                      wb1_en,
    input  logic [AW-1:0]             wb1_reg,
    output logic [NREG-1:0]           busy,
    output logic [NREG-1:0][CW-1:0]   remain
);

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        if (i == 0) begin : g_zero
            assign busy[i]   = 1'b0;
            assign remain[i] = '0;
        end else begin : g_reg
            localparam logic [AW-1:0] IDX = AW'(i);
            logic          hit0, hit1, clr;
            logic          busy_q;
            logic [CW-1:0] cnt_q;

            assign hit0 = set0_en && (set0_reg == IDX);
            assign hit1 = set1_en && (set1_reg == IDX);
            assign clr  = (wb0_en && (wb0_reg == IDX)) ||
                          (wb1_en && (wb1_reg == IDX));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end else if (hit0) begin
                    busy_q <= 1'b1;
                    cnt_q  <= set0_cnt;
                end else if (hit1) begin
                    busy_q <= 1'b1;
                    cnt_q  <= set1_cnt;
                end else begin
                    if (clr && (cnt_q == '0))
                        busy_q <= 1'b0;
                    if (cnt_q != '0)
                        cnt_q <= cnt_q - 1'b1;
                end
            end

            assign busy[i]   = busy_q;
            assign remain[i] = cnt_q;
        end
    end

endmodule

// File: rtl/dis_slot_check.sv
`timescale 1ns/1ps
module dis_slot_check
    import dis_pkg::*;
#(
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  fu_e                       unit,
    input  logic [AW-1:0]             dst,
    input  logic [AW-1:0]             src_a,
    input  logic [AW-1:0]             src_b,
    input  logic [NREG-1:0]           busy,
    input  logic [NREG-1:0][CW-1:0]   remain,
    input  logic                      older_en,
    input  logic [AW-1:0]             older_dst,
    input  fu_e                       older_unit,
    output logic                      clear,
    output logic [CW-1:0]             lat_m1
);

    logic [CW-1:0] lat;
    logic          raw_hz, waw_hz, pair_hz;

    always_comb begin
        lat    = (unit == FU_MUL) ? CW'(MUL_LAT) : CW'(ALU_LAT);
        lat_m1 = lat - 1'b1;

        raw_hz = ((src_a != '0) && busy[src_a]) ||
                 ((src_b != '0) && busy[src_b]);

        waw_hz = (dst != '0) && busy[dst] && (remain[dst] >= lat);

        pair_hz = older_en && (
                      (unit == older_unit) ||
                      ((src_a != '0) && (src_a == older_dst)) ||
                      ((src_b != '0) && (src_b == older_dst)) ||
                      ((dst   != '0) && (dst   == older_dst)));

        clear = !raw_hz && !waw_hz && !pair_hz;
    end

endmodule

// File: rtl/dis_port_fsm.sv
`timescale 1ns/1ps
module dis_port_fsm
    import dis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mul_issued,
    output logic port_reserved
);

    port_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WB_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_CLEAR:    state_d = mul_issued ? WB_RESERVED : WB_CLEAR;
            WB_RESERVED: state_d = mul_issued ? WB_RESERVED : WB_CLEAR;
            default:     state_d = WB_CLEAR;
        endcase
    end

    always_comb begin
        port_reserved = (state_q == WB_RESERVED);
    end

endmodule

// File: rtl/dis_issue_ctl.sv
`timescale 1ns/1ps
module dis_issue_ctl
    import dis_pkg::*;
#(
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s0_valid,
    input  logic [1:0]      s0_unit,
    input  logic [AW-1:0]   s0_dst,
    input  logic [AW-1:0]   s0_src_a,
    input  logic [AW-1:0]   s0_src_b,
    input  logic            s1_valid,
    input  logic [1:0]      s1_unit,
    input  logic [AW-1:0]   s1_dst,
    input  logic [AW-1:0]   s1_src_a,
    input  logic [AW-1:0]   s1_src_b,
    input  logic            wb0_valid,
    input  logic [AW-1:0]   wb0_reg,
    input  logic            wb1_valid,
    input  logic [AW-1:0]   wb1_reg,
    output logic [1:0]      issue_cnt,
    output logic [NREG-1:0] reg_busy
);

    fu_e                     u0, u1;
    logic [NREG-1:0]         busy;
    logic [NREG-1:0][CW-1:0] remain;
    logic                    ok0, ok1;
    logic [CW-1:0]           lat0_m1, lat1_m1;
    logic                    port_reserved, port_block;
    logic                    go0, go1, mul_issued;

    assign u0 = fu_norm(s0_unit);
    assign u1 = fu_norm(s1_unit);

    dis_scoreboard #(.NREG(NREG), .AW(AW)) sb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set0_en  (go0 && (s0_dst != '0)),
        .set0_reg (s0_dst),
        .set0_cnt (lat0_m1),
        .set1_en  (go1 && (s1_dst != '0)),
        .set1_reg (s1_dst),
        .set1_cnt (lat1_m1),
        .wb0_en   (wb0_valid),
        .wb0_reg  (wb0_reg),
        .wb1_en   (wb1_valid),
        .wb1_reg  (wb1_reg),
        .busy     (busy),
        .remain   (remain)
    );

    dis_slot_check #(.NREG(NREG), .AW(AW)) chk0_i (
        .unit       (u0),
        .dst        (s0_dst),
        .src_a      (s0_src_a),
        .src_b      (s0_src_b),
        .busy       (busy),
        .remain     (remain),
        .older_en   (1'b0),
        .older_dst  ('0),
        .older_unit (FU_ADD),
        .clear      (ok0),
        .lat_m1     (lat0_m1)
    );

    dis_slot_check #(.NREG(NREG), .AW(AW)) chk1_i (
        .unit       (u1),
        .dst        (s1_dst),
        .src_a      (s1_src_a),
        .src_b      (s1_src_b),
        .busy       (busy),
        .remain     (remain),
        .older_en   (1'b1),
        .older_dst  (s0_dst),
        .older_unit (u0),
        .clear      (ok1),
        .lat_m1     (lat1_m1)
    );

    dis_port_fsm port_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mul_issued    (mul_issued),
        .port_reserved (port_reserved)
    );

    always_comb begin
        port_block = port_reserved && (u0 != FU_MUL) && (u1 != FU_MUL);
        go0        = s0_valid && ok0;
        go1        = go0 && s1_valid && ok1 && !port_block;
        mul_issued = (go0 && (u0 == FU_MUL)) || (go1 && (u1 == FU_MUL));
        issue_cnt  = {go1, go0 && !go1};
    end

    assign reg_busy = busy;

endmodule

// File: rtl/dis_issue_chk.sv
`timescale 1ns/1ps
module dis_issue_chk
    import dis_pkg::*;
#(
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            s0_valid,
    input logic [1:0]      s0_unit,
    input logic [AW-1:0]   s0_dst,
    input logic [AW-1:0]   s0_src_a,
    input logic            s1_valid,
    input logic [1:0]      s1_unit,
    input logic [AW-1:0]   s1_dst,
    input logic [1:0]      issue_cnt,
    input logic [NREG-1:0] reg_busy
);

    logic mul_prev;
    logic mul_now;

    assign mul_now = ((issue_cnt != 2'd0) && (fu_norm(s0_unit) == FU_MUL)) ||
                     ((issue_cnt == 2'd2) && (fu_norm(s1_unit) == FU_MUL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mul_prev <= 1'b0;
        else        mul_prev <= mul_now;
    end

    AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        issue_cnt != 2'd3);  // R1

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt != 2'd0) |-> s0_valid);  // R2

    AST_PAIR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> s1_valid);  // R2

    AST_SAME_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s1_valid && (fu_norm(s0_unit) == fu_norm(s1_unit))) |-> (issue_cnt != 2'd2));  // R3

    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && (s0_src_a != '0) && reg_busy[s0_src_a]) |-> (issue_cnt == 2'd0));  // R4

    AST_PAIR_WAW: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s0_dst != '0) && (s1_dst == s0_dst)) |-> (issue_cnt != 2'd2));  // R6

    AST_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_busy[0]);  // R7

    AST_PORT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_prev && s0_valid && s1_valid && (fu_norm(s0_unit) != FU_MUL) &&
         (fu_norm(s1_unit) != FU_MUL)) |-> (issue_cnt != 2'd2));  // R8

    AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_cnt != 2'd0) && (s0_dst != '0)) |=> reg_busy[$past(s0_dst)]);  // R9

endmodule

bind dis_issue_ctl dis_issue_chk #(.NREG(NREG), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .s0_valid  (s0_valid),
    .s0_unit   (s0_unit),
    .s0_dst    (s0_dst),
    .s0_src_a  (s0_src_a),
    .s1_valid  (s1_valid),
    .s1_unit   (s1_unit),
    .s1_dst    (s1_dst),
    .issue_cnt (issue_cnt),
    .reg_busy  (reg_busy)
);

// File: tb/dis_issue_ctl_tb_top.sv
`timescale 1ns/1ps
module dis_issue_ctl_tb_top;

    localparam int NREG = 32;
    localparam int AW   = 5;
    localparam int NV   = 19;

    typedef struct packed {
        logic          s0v;
        logic [1:0]    s0u;
        logic [AW-1:0] s0d, s0a, s0b;
        logic          s1v;
        logic [1:0]    s1u;
        logic [AW-1:0] s1d, s1a, s1b;
        logic          w0v;
        logic [AW-1:0] w0r;
        logic          w1v;
        logic [AW-1:0] w1r;
        logic [1:0]    exp;
    } vec_t;

    // Units: 0 add, 1 shift, 2 multiply, 3 = add. Walked one vector per cycle.
    localparam vec_t VEC [NV] = '{
        '{1,0, 1, 2, 3, 1,1, 4, 5, 6, 0, 0,0, 0, 2}, // 0  R1 independent pair
        '{1,2, 7, 1, 0, 1,0,29, 0, 0, 1, 1,1, 4, 0}, // 1  R4 src busy, wb same cycle; R2
        '{1,2, 7, 1, 2, 1,2, 8, 3, 0, 0, 0,0, 0, 1}, // 2  R3 two multiplies
        '{1,0, 9, 2, 3, 1,1,10, 0, 0, 0, 0,0, 0, 1}, // 3  R8 port reserved
        '{1,0,11, 7, 0, 0,0, 0, 0, 0, 1, 7,1, 9, 0}, // 4  R4 mul result still busy
        '{1,0,11, 7, 0, 1,0,12, 0, 0, 0, 0,0, 0, 1}, // 5  R3 two adds
        '{1,1,13, 0, 0, 1,0,14,13, 0, 1,11,0, 0, 1}, // 6  R6 pair RAW
        '{1,0,15, 0, 0, 1,1,15, 0, 0, 1,13,0, 0, 1}, // 7  R6 pair WAW
        '{1,0, 0, 0, 0, 1,1, 0, 0, 0, 1,15,0, 0, 2}, // 8  R7 register zero
        '{1,0, 5, 0, 0, 1,1, 6, 0, 0, 0, 0,0, 0, 2}, // 9  R1
        '{1,2,20, 0, 0, 1,0,21, 0, 0, 1, 5,1, 6, 2}, // 10 R3 mul + add
        '{1,0,20, 0, 0, 1,1,28, 0, 0, 1,21,0, 0, 0}, // 11 R5 WAW over mul; R2
        '{1,2,22, 0, 0, 0,0, 0, 0, 0, 1,20,0, 0, 1}, // 12 R9 wb clears
        '{1,2,22, 0, 0, 1,1,23, 0, 0, 0, 0,0, 0, 2}, // 13 R5 mul over mul allowed; R3
        '{0,0, 0, 0, 0, 1,0,24, 0, 0, 1,22,1,23, 0}, // 14 R2 older invalid
        '{1,0,25,22, 0, 0,0, 0, 0, 0, 1,22,0, 0, 0}, // 15 R9 stale wb ignored
        '{1,0,25,22, 0, 0,0, 0, 0, 0, 0, 0,0, 0, 1}, // 16 R9 cleared by newest wb
        '{1,3,26, 0, 0, 1,0,27, 0, 0, 1,25,0, 0, 1}, // 17 R3 code 3 is adder
        '{0,0, 0, 0, 0, 0,0, 0, 0, 0, 1,26,0, 0, 0}  // 18 R1 idle
    };

    function automatic string vec_tag(input int i);
        case (i)
            1, 4:        return "R4";
            2, 5, 10, 17: return "R3";
            3:           return "R8";
            6, 7:        return "R6";
            8:           return "R7";
            11, 13:      return "R5";
            14:          return "R2";
            12, 15, 16:  return "R9";
            default:     return "R1";
        endcase
    endfunction

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            s0_valid, s1_valid, wb0_valid, wb1_valid;
    logic [1:0]      s0_unit, s1_unit;
    logic [AW-1:0]   s0_dst, s0_src_a, s0_src_b;
    logic [AW-1:0]   s1_dst, s1_src_a, s1_src_b;
    logic [AW-1:0]   wb0_reg, wb1_reg;
    logic [1:0]      issue_cnt;
    logic [NREG-1:0] reg_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dis_issue_ctl #(.NREG(NREG), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_unit(s0_unit), .s0_dst(s0_dst),
        .s0_src_a(s0_src_a), .s0_src_b(s0_src_b),
        .s1_valid(s1_valid), .s1_unit(s1_unit), .s1_dst(s1_dst),
        .s1_src_a(s1_src_a), .s1_src_b(s1_src_b),
        .wb0_valid(wb0_valid), .wb0_reg(wb0_reg),
        .wb1_valid(wb1_valid), .wb1_reg(wb1_reg),
        .issue_cnt(issue_cnt), .reg_busy(reg_busy)
    );

    task automatic apply(input vec_t v);
        s0_valid = v.s0v; s0_unit = v.s0u; s0_dst = v.s0d; s0_src_a = v.s0a; s0_src_b = v.s0b;
        s1_valid = v.s1v; s1_unit = v.s1u; s1_dst = v.s1d; s1_src_a = v.s1a; s1_src_b = v.s1b;
        wb0_valid = v.w0v; wb0_reg = v.w0r; wb1_valid = v.w1v; wb1_reg = v.w1r;
    endtask

    task automatic idle();
        apply('0);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R10 reset busy", 64'(reg_busy), 64'd0);
        check("R1 reset idle count", 64'(issue_cnt), 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            check($sformatf("%s vec %0d", vec_tag(i), i), 64'(issue_cnt), 64'(VEC[i].exp));
        end
        @(negedge clk);
        idle();
        #1;
        check("R9 all released", 64'(reg_busy), 64'd0);

        // R11 / R7: busy flags visible; register zero stays free
        apply('{1,0,9,0,0, 1,1,0,0,0, 0,0,0,0, 0});
        @(negedge clk);
        idle();
        #1;
        check("R11 r9 busy", 64'(reg_busy), 64'(32'h0000_0200));
        check("R7 r0 free", 64'(reg_busy[0]), 64'd0);
        apply('{0,0,0,0,0, 0,0,0,0,0, 1,9,0,0, 0});
        @(negedge clk);
        idle();
        #1;
        check("R9 r9 released", 64'(reg_busy), 64'd0);

        // R10: reset in the middle of an in-flight multiply
        apply('{1,2,3,0,0, 0,0,0,0,0, 0,0,0,0, 0});
        @(negedge clk);
        idle();
        #1;
        check("R11 r3 busy", 64'(reg_busy[3]), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 busy cleared", 64'(reg_busy), 64'd0);
        apply('{1,0,4,3,0, 1,1,5,0,0, 0,0,0,0, 0});
        #1;
        check("R10 port state clear, reader of r3 issues", 64'(issue_cnt), 64'd2);
        @(negedge clk);
        idle();
        finish_run();
    end

endmodule